// File: doc/BRIEF.md
# Memory-to-Memory Byte Copy Engine

This block moves a run of bytes from one region of memory to another without processor involvement. Software presents a source base address, a destination base address, a byte count and three option bits (source direction, destination direction, fixed source). It then pulses `start`. The engine latches those values into working counters and copies one byte at a time. Each byte takes a read cycle and then a write cycle on a single synchronous memory port. The byte fetched in the read cycle is parked in an internal 8-bit holding register and driven out in the following write cycle.

The source address counter belongs to one channel. The destination address counter and the remaining-byte counter belong to a second channel. Each address counter steps up or down on its own. The source counter can also be frozen, so that a region is filled with copies of a single byte. The copy ends when the byte counter runs out or when the external `stop` line is raised. `done` then pulses for one cycle.

The memory port is a plain synchronous one. `mem_rdata` must be valid during a read cycle, and a write happens at the clock edge that ends a cycle with `mem_wr` high.

Top module: `copy_engine`

## Requirements
- R1: After synchronous reset, `mem_rd`, `mem_wr` and `done` are low, and no memory cycle starts until `start` is seen.
- R2: A `start` pulse sampled while idle latches all configuration inputs. Byte k (counting from 0) is read in cycle 2k+1 after the start edge, with `mem_addr` equal to the source address. It is written in cycle 2k+2 with `mem_addr` equal to the destination address and `mem_wdata` equal to the byte that was read.
- R3: `mem_rd` and `mem_wr` are never high together, and every read cycle is followed directly by a write cycle.
- R4: After each byte, the source and destination addresses each move by +1 when their direction bit is 0 and by -1 when it is 1, independently of one another.
- R5: With `src_fixed` = 1, every read uses the source base address, and the destination still steps.
- R6: With a nonzero count N and no stop, exactly N bytes are copied. `done` is high for exactly one cycle, cycle 2N+1 after the start edge.
- R7: A count of 0 produces no memory cycle, and `done` pulses in cycle 1 after the start edge.
- R8: If `stop` is high at the clock edge that ends copy cycle c, the byte in flight still completes its write and no further byte starts. The number of bytes copied is min(N, floor((c-1)/2)+1), and `done` follows as in R6.
- R9: `start` raised during a copy has no effect, even if the configuration inputs change at the same time. `stop` raised while idle has no effect.
- R10: Address counters wrap modulo 2^AW, so 0xFFFF+1 is 0x0000 and 0x0000-1 is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a copy (sampled while idle) |
| src_base | input | AW | Source base address |
| dst_base | input | AW | Destination base address |
| xfer_len | input | CW | Number of bytes to copy |
| src_down | input | 1 | Source steps downward when 1 |
| dst_down | input | 1 | Destination steps downward when 1 |
| src_fixed | input | 1 | Keep source address constant |
| stop | input | 1 | End the copy after the byte in flight |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data from holding register |
| mem_rdata | input | DW | Read data |
| done | output | 1 | One-cycle end-of-copy pulse |

## Verification
The embedded properties check the following on every cycle: the two strobes exclude each other, each read is followed by a write, `done` lasts a single cycle and never overlaps a memory cycle, the byte counter stays nonzero while busy, and a frozen source address stays fixed. What the properties cannot show is the end-to-end result. The bench covers that: the exact address sequence across the 64K wrap, the data carried from each read into its write, the byte count cut short by `stop` in read and write cycles, and a second `start` that is ignored in mid-copy. It checks these over directed and seeded random copies.

// File: rtl/copy_pkg.sv
package copy_pkg;

    typedef enum logic [1:0] {
        CP_IDLE = 2'd0,
        CP_RD   = 2'd1,
        CP_WR   = 2'd2
    } cp_state_e;

    typedef struct packed {
        logic down;
        logic hold;
    } step_cfg_t;

    localparam int NUM_CH = 2;
    localparam int CH_SRC = 0;
    localparam int CH_DST = 1;

endpackage

// File: rtl/copy_addr_ctr.sv
module copy_addr_ctr
    import copy_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  step_cfg_t     load_cfg,
    input  logic          step,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] addr_q;
    step_cfg_t     cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cfg_q  <= '0;
        end else if (load) begin
            addr_q <= load_val;
            cfg_q  <= load_cfg;
        end else if (step && !cfg_q.hold) begin
            addr_q <= cfg_q.down ? addr_q - ONE : addr_q + ONE;
        end
    end

    assign addr = addr_q;

    // R5: a frozen counter keeps its value across a step
    p_hold_fixed_r5: assert property (@(posedge clk) disable iff (rst)
        (step && !load && cfg_q.hold) |=> $stable(addr_q));

    // R4: a free counter moves on every step
    p_step_moves_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !cfg_q.hold) |=> (addr_q != $past(addr_q)));

    // R4: no movement without load or step
    p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(addr_q));

endmodule

// File: rtl/copy_ctrl.sv
module copy_ctrl
    import copy_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] xfer_len,
    input  logic          stop,
    output logic          rd,
    output logic          wr,
    output logic          load,
    output logic          step,
    output logic          done
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    cp_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic          stop_q;
    logic          done_q;
    logic          last_byte;

    assign last_byte = (cnt_q == ONE) || stop_q || stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CP_IDLE;
            cnt_q   <= '0;
            stop_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                CP_IDLE: begin
                    stop_q <= 1'b0;
                    if (start) begin
                        if (xfer_len == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            cnt_q   <= xfer_len;
                            state_q <= CP_RD;
                        end
                    end
                end
                CP_RD: begin
                    if (stop) stop_q <= 1'b1;
                    state_q <= CP_WR;
                end
                CP_WR: begin
                    cnt_q <= cnt_q - ONE;
                    if (last_byte) begin
                        state_q <= CP_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        state_q <= CP_RD;
                    end
                end
                default: state_q <= CP_IDLE;
            endcase
        end
    end

    assign rd   = (state_q == CP_RD);
    assign wr   = (state_q == CP_WR);
    assign load = (state_q == CP_IDLE) && start;
    assign step = (state_q == CP_WR);
    assign done = done_q;

    // R3: strobes never overlap
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(rd && wr));

    // R3: a read cycle is always followed by a write cycle
    p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (rst)
        rd |=> wr);

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: byte counter never exhausted while a copy is live
    p_cnt_live_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q != CP_IDLE) |-> (cnt_q != '0));

    // R7: done never coincides with a memory cycle
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!rd && !wr));

endmodule

// File: rtl/copy_engine.sv
module copy_engine
    import copy_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [CW-1:0] xfer_len,
    input  logic          src_down,
    input  logic          dst_down,
    input  logic          src_fixed,
    input  logic          stop,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          done
);
    logic          rd, wr, load, step;
    logic [AW-1:0] base_v [NUM_CH];
    step_cfg_t     cfg_v  [NUM_CH];
    logic [AW-1:0] addr_v [NUM_CH];
    logic [DW-1:0] hold_q;

    assign base_v[CH_SRC] = src_base;
    assign base_v[CH_DST] = dst_base;
    assign cfg_v[CH_SRC]  = '{down: src_down, hold: src_fixed};
    assign cfg_v[CH_DST]  = '{down: dst_down, hold: 1'b0};

    copy_ctrl #(.CW(CW)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .xfer_len (xfer_len),
        .stop     (stop),
        .rd       (rd),
        .wr       (wr),
        .load     (load),
        .step     (step),
        .done     (done)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        copy_addr_ctr #(.AW(AW)) ctr_i (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .load_val (base_v[ch]),
            .load_cfg (cfg_v[ch]),
            .step     (step),
            .addr     (addr_v[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)     hold_q <= '0;
        else if (rd) hold_q <= mem_rdata;
    end

    assign mem_addr  = wr ? addr_v[CH_DST] : addr_v[CH_SRC];
    assign mem_rd    = rd;
    assign mem_wr    = wr;
    assign mem_wdata = hold_q;

    // R2: the write data is the byte captured in the preceding read
    p_wdata_src_r2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (mem_wdata == $past(mem_rdata)));

endmodule

// File: tb/copy_engine_tb_top.sv
module copy_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start, stop;
    logic [15:0] src_base, dst_base, xfer_len;
    logic        src_down, dst_down, src_fixed;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, done;
    logic [7:0]  mem_wdata, mem_rdata;

    always #5 clk = ~clk;

    copy_engine dut_i (
        .clk(clk), .rst(rst), .start(start), .src_base(src_base),
        .dst_base(dst_base), .xfer_len(xfer_len), .src_down(src_down),
        .dst_down(dst_down), .src_fixed(src_fixed), .stop(stop),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done)
    );

    function automatic logic [7:0] mem_fn(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    assign mem_rdata = mem_fn(mem_addr);

    int n_chk = 0, n_bad = 0;
    logic active = 1'b0;
    int cyc, stop_at, restart_at;
    int rd_n, wr_n, done_n, done_cyc;
    logic [15:0] rd_a [64];
    logic [15:0] wr_a [64];
    logic [7:0]  wr_d [64];
    int rd_c [64];
    int wr_c [64];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(negedge clk) begin
        if (active) begin
            cyc = cyc + 1;
            stop = (cyc == stop_at);
            start = (cyc == restart_at);
            if (start) begin
                src_base = ~src_base; dst_base = ~dst_base;
                xfer_len = 16'd3; src_down = ~src_down; src_fixed = ~src_fixed;
            end
            if (mem_rd && rd_n < 64) begin
                rd_a[rd_n] = mem_addr; rd_c[rd_n] = cyc; rd_n++;
            end
            if (mem_wr && wr_n < 64) begin
                wr_a[wr_n] = mem_addr; wr_d[wr_n] = mem_wdata; wr_c[wr_n] = cyc; wr_n++;
            end
            if (done) begin
                done_n++; done_cyc = cyc;
            end
        end
    end

    function automatic logic [15:0] step_addr(input logic [15:0] b, input int k,
                                               input bit down);
        logic [15:0] kk = 16'(k);
        return down ? b - kk : b + kk;
    endfunction

    task automatic run_copy(input logic [15:0] s, input logic [15:0] d,
                            input int len, input bit sd, input bit dd, input bit hf,
                            input int stp, input int rs);
        int exp_n;
        logic [15:0] ea;
        @(negedge clk);
        src_base = s; dst_base = d; xfer_len = 16'(len);
        src_down = sd; dst_down = dd; src_fixed = hf;
        stop_at = stp; restart_at = rs; cyc = 0;
        rd_n = 0; wr_n = 0; done_n = 0; done_cyc = -1;
        start = 1'b1;
        @(posedge clk);
        active = 1'b1;
        repeat (2 * len + 10) @(negedge clk);
        active = 1'b0;
        start = 1'b0; stop = 1'b0;
        exp_n = len;
        if (stp > 0 && ((stp - 1) / 2 + 1) < exp_n) exp_n = (stp - 1) / 2 + 1;
        if (len == 0) check(rd_n == 0 && wr_n == 0, "R7", "memory cycles for zero count", rd_n + wr_n, 0);
        if (stp > 0) check(wr_n == exp_n, "R8", "bytes after stop", wr_n, exp_n);
        else         check(wr_n == exp_n, "R6", "bytes written", wr_n, exp_n);
        if (rs > 0)  check(wr_n == exp_n, "R9", "bytes with restart in flight", wr_n, exp_n);
        check(rd_n == exp_n, "R6", "bytes read", rd_n, exp_n);
        check(done_n == 1, "R6", "done pulse count", done_n, 1);
        check(done_cyc == 2 * exp_n + 1, "R6", "done cycle", done_cyc, 2 * exp_n + 1);
        for (int k = 0; k < exp_n && k < rd_n && k < wr_n; k++) begin
            ea = hf ? s : step_addr(s, k, sd);
            if (hf) check(rd_a[k] == ea, "R5", "fixed source addr", int'(rd_a[k]), int'(ea));
            else    check(rd_a[k] == ea, "R4", "source addr", int'(rd_a[k]), int'(ea));
            check(rd_c[k] == 2 * k + 1, "R2", "read cycle", rd_c[k], 2 * k + 1);
            check(wr_c[k] == rd_c[k] + 1, "R3", "write follows read", wr_c[k], rd_c[k] + 1);
            check(wr_d[k] == mem_fn(ea), "R2", "written data", int'(wr_d[k]), int'(mem_fn(ea)));
            ea = step_addr(d, k, dd);
            check(wr_a[k] == ea, "R4", "dest addr", int'(wr_a[k]), int'(ea));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int unsigned seed;
        int len, stp;
        logic [15:0] rs_a, rd_b;
        seed = 32'h0000_5EED;
        void'($urandom(seed));
        rst = 1'b1; start = 1'b0; stop = 1'b0;
        src_base = '0; dst_base = '0; xfer_len = '0;
        src_down = 1'b0; dst_down = 1'b0; src_fixed = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check(!mem_rd && !mem_wr && !done, "R1", "strobes after reset",
              {mem_rd, mem_wr, done}, 0);

        // R9: stop while idle changes nothing
        stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(!mem_rd && !mem_wr && !done, "R9", "idle after stop", {mem_rd, mem_wr, done}, 0);
        end

        run_copy(16'h1000, 16'h2000, 5, 0, 0, 0, 0, 0);       // R2 R6 basic
        run_copy(16'h1234, 16'h4321, 0, 0, 0, 0, 0, 0);       // R7 zero count
        run_copy(16'h00AA, 16'h0BB0, 1, 1, 1, 0, 0, 0);       // R6 single byte
        run_copy(16'hFFFE, 16'h0001, 4, 0, 1, 0, 0, 0);       // R10 wrap both ways
        run_copy(16'h0777, 16'h3000, 6, 0, 0, 1, 0, 0);       // R5 fill
        run_copy(16'h5000, 16'h6000, 8, 1, 0, 0, 0, 0);       // R4 mixed directions
        run_copy(16'h0100, 16'h0200, 10, 0, 0, 0, 5, 0);      // R8 stop in read cycle
        run_copy(16'h0100, 16'h0200, 10, 0, 0, 0, 6, 0);      // R8 stop in write cycle
        run_copy(16'h0300, 16'h0400, 7, 0, 1, 0, 0, 4);       // R9 restart ignored

        for (int i = 0; i < 12; i++) begin
            len = $urandom_range(1, 24);
            stp = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 2 * len) : 0;
            rs_a = 16'($urandom);
            rd_b = 16'($urandom);
            run_copy(rs_a, rd_b, len, 1'($urandom), 1'($urandom),
                     1'($urandom_range(0, 3) == 0), stp, 0);
        end
        report();
    end
endmodule